// File: doc/BRIEF.md
# Comparator-terminated synchronous buck PWM controller

This block produces the two gate-enable signals for a synchronous step-down converter. A free-running period counter divides the system clock into fixed switching periods. The default is 125 clocks, which gives 200 kHz from a 25 MHz clock. At the start of each period the high-side enable is raised. It stays high until one of three events occurs: the external voltage-feedback comparator reports that the output has reached its reference, an overcurrent flag is raised, or an on-time ceiling expires. After a single dead clock, the low-side enable carries the switch node for the rest of the period. It is released one dead clock before the next period begins.

The comparator output arrives without a clock relationship, so it passes through a flip-flop synchroniser. Once a pulse has been cut short, it stays off until the period boundary, so a chattering comparator cannot restart it. An optional soft-start ramp starts the on-time ceiling at zero after enable and raises it by one clock every few periods until it reaches the ceiling. A period strobe marks the cycle in which each new period's high-side pulse may begin.

Top module: `buck_pwm_ctrl`

## Requirements
- R1: `period_stb` is high for one cycle out of every PERIOD cycles. The first strobe comes one cycle after `en` rises.
- R2: With the comparator and the overcurrent flag idle, `hs_gate` rises in the strobe cycle and stays high for exactly the current on-time limit. That limit is never more than MAX_ON cycles (default 121 of 125).
- R3: The comparator is synchronised through two flip-flops. If it is asserted during period position t (the strobe cycle is position 1), the pulse width is min(t+2, limit).
- R4: A pulse ended by the comparator stays off for the rest of that period, even if the comparator deasserts again. The next period starts normally.
- R5: Each transition between the outputs has one cycle with both outputs low. For a high-side width w>0, `ls_gate` is high for PERIOD-2-w cycles. For w=0 it is high for PERIOD-1 cycles.
- R6: `hs_gate` and `ls_gate` are never high in the same cycle.
- R7: If `oc_flag` is high during position t, `hs_gate` is low from the next cycle. The pulse width is min(t, limit).
- R8: After any cycle of `oc_flag` in a period, the following period has no high-side pulse at all. The period after that is normal again.
- R9: With SOFT_START=1, period k after enable (k from 0) has an on-time limit of min(floor(k/SS_DIV), MAX_ON).
- R10: Deasserting `en` drives both outputs low on the next cycle. On re-enable, both the period counter and the soft-start ramp restart from zero.
- R11: While `rst_n` is low at a clock edge, all outputs are low after that edge.
- R12: With SOFT_START=0, the limit is MAX_ON from the first period after enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Converter enable; low forces both gates off |
| fb_cmp | input | 1 | Asynchronous feedback comparator, high when the output has reached the reference |
| oc_flag | input | 1 | Synchronous overcurrent indication |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |
| period_stb | output | 1 | One-cycle marker of each period's first pulse cycle |

## Verification
Each result has a fixed latency:
- `period_stb` appears one cycle after enable or after the counter wraps.
- A comparator edge removes the high-side pulse three cycles later: two synchroniser flops and the output register.
- The overcurrent flag and the enable drop both act on the following cycle.

The bench drives inputs and samples outputs on the falling edge, with the strobe cycle counted as period position 1. Every stimulus is placed at a known position, and the high- and low-side widths are counted across exactly one period window. The expected widths are then computed from these latencies, both for the period that received the stimulus and for the period after it.

// File: rtl/buck_pwm_pkg.sv
// Shared types and helpers for the buck PWM controller.
// Assumes: nothing beyond IEEE 1800-2017.
package buck_pwm_pkg;

    // Pair of gate enables carried between the sequencer and the top.
    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    // Counter width for values 0..n-1, never below one bit.
    function automatic int unsigned cw(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bpc_period_timer.sv
// Switching-period counter. Counts 0..PERIOD-1 while enabled and holds
// zero while disabled, so the first enabled cycle is position zero.
// Assumes: PERIOD >= 4.
module bpc_period_timer #(
    parameter int PERIOD = 125,
    parameter int CW     = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          start
);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    // Advance the position counter, restarting at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign wrap  = en && (cnt == LAST);
    assign start = en && (cnt == '0);

    // The counter never leaves its range (R1).
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // A disabled counter sits at zero on the next cycle (R10).
    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);
endmodule

// File: rtl/bpc_fb_sync.sv
// Multi-flop synchroniser for the asynchronous feedback comparator.
// Assumes: STAGES >= 2; the comparator is a level, not a short pulse.
module bpc_fb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] sh;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d_async};
    end

    assign q_sync = sh[STAGES-1];
endmodule

// File: rtl/bpc_on_limit.sv
// On-time ceiling. With SOFT_START set it starts at zero after enable and
// rises by one clock every SS_DIV periods until it reaches MAX_ON.
// Otherwise it is the constant MAX_ON.
// Assumes: MAX_ON < PERIOD, SS_DIV >= 1.
module bpc_on_limit #(
    parameter int CW         = 7,
    parameter int MAX_ON     = 121,
    parameter int SS_DIV     = 16,
    parameter bit SOFT_START = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wrap,
    output logic [CW-1:0] lim
);
    import buck_pwm_pkg::*;

    localparam logic [CW-1:0] LMAX = CW'(MAX_ON);

    generate
        if (SOFT_START) begin : g_ramp
            localparam int PW = cw(SS_DIV);
            localparam logic [PW-1:0] PDIV_LAST = PW'(SS_DIV - 1);

            logic [PW-1:0] pcnt;
            logic [CW-1:0] lim_q;

            // Count periods and step the ceiling up once per SS_DIV periods.
            always_ff @(posedge clk) begin
                if (!rst_n || !en) begin
                    pcnt  <= '0;
                    lim_q <= '0;
                end else if (wrap) begin
                    if (pcnt == PDIV_LAST) begin
                        pcnt <= '0;
                        if (lim_q != LMAX) lim_q <= lim_q + 1'b1;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
            end

            assign lim = lim_q;

            // While enabled, the ceiling only ever grows by one step (R9).
            p_ramp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (en && $past(en) && !$stable(lim_q)) |-> lim_q == $past(lim_q) + 1'b1);

            // The ceiling never passes the maximum duty (R2).
            p_ramp_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
                lim_q <= LMAX);
        end else begin : g_fixed
            assign lim = LMAX;
        end
    endgenerate
endmodule

// File: rtl/bpc_gate_seq.sv
// Gate sequencer. Decides per cycle whether the high or the low switch
// conducts, ends the pulse on comparator, overcurrent or ceiling, latches
// the ending until the period boundary, and enforces DEAD idle cycles
// between the two enables. Outputs are registered.
// Assumes: MAX_ON + 2*DEAD + 1 <= PERIOD, DEAD >= 1, oc is synchronous.
module bpc_gate_seq #(
    parameter int PERIOD = 125,
    parameter int MAX_ON = 121,
    parameter int DEAD   = 1,
    parameter int CW     = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [CW-1:0]            cnt,
    input  logic                     wrap,
    input  logic [CW-1:0]            lim,
    input  logic                     fb_s,
    input  logic                     oc,
    output buck_pwm_pkg::gate_pair_t gates
);
    import buck_pwm_pkg::*;

    localparam int DW = cw(DEAD + 1);
    localparam logic [DW-1:0] DEAD_C  = DW'(DEAD);
    localparam logic [DW-1:0] DEAD_M1 = DW'(DEAD - 1);
    localparam logic [CW-1:0] LS_END  = CW'(PERIOD - DEAD);
    localparam logic [CW-1:0] RUN_CAP = CW'(MAX_ON);

    logic          term_q;   // pulse ended in this period
    logic          oc_seen;  // overcurrent seen in this period
    logic          oc_blk;   // overcurrent seen in the previous period
    logic [DW-1:0] low_cnt;  // consecutive idle cycles so far
    logic [CW-1:0] hs_run;   // consecutive high-side cycles so far
    logic          hs_want, ls_want, hs_fire, ls_fire, low_ok;

    // Schedule: what each switch would like to do at this position.
    always_comb begin
        hs_want = en && (cnt < lim) && !term_q && !fb_s && !oc && !oc_blk;
        ls_want = en && !hs_want && (cnt < LS_END);
    end

    // Break-before-make gating of the schedule.
    always_comb begin
        low_ok  = (low_cnt >= DEAD_M1);
        hs_fire = hs_want && !gates.ls && (gates.hs || low_ok);
        ls_fire = ls_want && !gates.hs && (gates.ls || low_ok);
    end

    // Latch the end of the pulse until the period wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) term_q <= 1'b0;
        else if (wrap)     term_q <= 1'b0;
        else if (fb_s || oc) term_q <= 1'b1;
    end

    // Remember overcurrent this period and block the following one.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            oc_seen <= 1'b0;
            oc_blk  <= 1'b0;
        end else if (wrap) begin
            oc_seen <= 1'b0;
            oc_blk  <= oc_seen || oc;
        end else if (oc) begin
            oc_seen <= 1'b1;
        end
    end

    // Register both gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) gates <= '0;
        else        gates <= '{hs: hs_fire, ls: ls_fire};
    end

    // Count idle cycles (both enables low), saturating at DEAD.
    always_ff @(posedge clk) begin
        if (!rst_n)                  low_cnt <= DEAD_C;
        else if (gates.hs || gates.ls) low_cnt <= '0;
        else if (low_cnt != DEAD_C)  low_cnt <= low_cnt + 1'b1;
    end

    // Track the length of the current high-side run.
    always_ff @(posedge clk) begin
        if (!rst_n)        hs_run <= '0;
        else if (gates.hs) hs_run <= hs_run + 1'b1;
        else               hs_run <= '0;
    end

    // Both switches never conduct together (R6).
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gates.hs && gates.ls));

    // An idle cycle follows the high side turning off (R5).
    p_dead_after_hs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gates.hs) |-> !gates.ls);

    // An idle cycle follows the low side turning off (R5).
    p_dead_after_ls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gates.ls) |-> !gates.hs);

    // A high-side run never exceeds the maximum on-time (R2).
    p_run_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gates.hs |-> hs_run < RUN_CAP);

    // Overcurrent removes the high side on the next cycle (R7).
    p_oc_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oc |=> !gates.hs);

    // A latched ending keeps the high side off (R4).
    p_latched_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        term_q |-> !gates.hs);

    // A blocked period carries no high-side pulse (R8).
    p_oc_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        oc_blk |=> !gates.hs);
endmodule

// File: rtl/buck_pwm_ctrl.sv
// Top of the comparator-terminated synchronous buck PWM controller.
// Wires the period counter, the comparator synchroniser, the on-time
// ceiling and the gate sequencer, and registers the period strobe.
// Assumes: oc_flag is synchronous to clk; fb_cmp may be asynchronous.
module buck_pwm_ctrl #(
    parameter int PERIOD      = 125,
    parameter int MAX_ON      = 121,
    parameter int DEAD        = 1,
    parameter int SS_DIV      = 16,
    parameter bit SOFT_START  = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fb_cmp,
    input  logic oc_flag,
    output logic hs_gate,
    output logic ls_gate,
    output logic period_stb
);
    import buck_pwm_pkg::*;

    localparam int CW = cw(PERIOD);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          wrap, start, fb_s, stb_q;
    gate_pair_t    gates;

    bpc_period_timer #(.PERIOD(PERIOD), .CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(en),
        .cnt(cnt), .wrap(wrap), .start(start)
    );

    bpc_fb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(fb_cmp), .q_sync(fb_s)
    );

    bpc_on_limit #(.CW(CW), .MAX_ON(MAX_ON), .SS_DIV(SS_DIV),
                   .SOFT_START(SOFT_START)) u_limit (
        .clk(clk), .rst_n(rst_n), .en(en), .wrap(wrap), .lim(lim)
    );

    bpc_gate_seq #(.PERIOD(PERIOD), .MAX_ON(MAX_ON), .DEAD(DEAD),
                   .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt), .wrap(wrap),
        .lim(lim), .fb_s(fb_s), .oc(oc_flag), .gates(gates)
    );

    // Register the strobe so it lines up with the first pulse cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= start;
    end

    assign hs_gate    = gates.hs;
    assign ls_gate    = gates.ls;
    assign period_stb = stb_q;

    // The high side only turns on in a strobe cycle (R2).
    p_hs_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> period_stb);

    // Dropping enable releases both gates on the next cycle (R10).
    p_en_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_gate && !ls_gate));

    // A strobe never repeats in back-to-back cycles (R1).
    p_stb_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        period_stb |=> !period_stb);
endmodule

// File: tb/test_buck_pwm_ctrl.sv
`timescale 1ns/1ps
module test_buck_pwm_ctrl;
    localparam int BP = 20;   // period
    localparam int BL = 16;   // max on-time
    localparam int BD = 1;    // dead cycles
    localparam int BS = 2;    // soft-start divider
    localparam int NV = 10;
    // Columns: comparator position, overcurrent position (0 = none),
    //          expected width this period, expected width next period.
    localparam int VEC [NV][4] = '{
        '{0,  0,  16, 16},
        '{3,  0,  5,  16},
        '{1,  0,  3,  16},
        '{14, 0,  16, 16},
        '{13, 0,  15, 16},
        '{0,  4,  4,  0 },
        '{0,  19, 16, 0 },
        '{5,  3,  3,  0 },
        '{10, 12, 12, 0 },
        '{0,  1,  1,  0 }
    };

    logic clk = 1'b0;
    logic rst_n, en, fb_cmp, oc_flag;
    logic hs_gate, ls_gate, period_stb;
    logic fx_hs, fx_ls, fx_stb;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    buck_pwm_ctrl #(.PERIOD(BP), .MAX_ON(BL), .DEAD(BD), .SS_DIV(BS),
                    .SOFT_START(1'b1)) i_buck_pwm_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .fb_cmp(fb_cmp), .oc_flag(oc_flag),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .period_stb(period_stb)
    );

    buck_pwm_ctrl #(.PERIOD(BP), .MAX_ON(BL), .DEAD(BD), .SS_DIV(BS),
                    .SOFT_START(1'b0)) i_buck_pwm_ctrl_fixed (
        .clk(clk), .rst_n(rst_n), .en(en), .fb_cmp(fb_cmp), .oc_flag(oc_flag),
        .hs_gate(fx_hs), .ls_gate(fx_ls), .period_stb(fx_stb)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ls_exp(input int w);
        return (w == 0) ? BP - BD : BP - 2 * BD - w;
    endfunction

    // Called on the falling edge of a strobe cycle (position 1); returns on
    // the falling edge of the next strobe cycle.
    task automatic run_period(input int fb_at, input int oc_at,
                              output int hsw, output int lsw, output int fxw);
        hsw = 0; lsw = 0; fxw = 0;
        for (int off = 1; off <= BP; off++) begin
            hsw += int'(hs_gate);
            lsw += int'(ls_gate);
            fxw += int'(fx_hs);
            fb_cmp  = (off == fb_at);
            oc_flag = (off == oc_at);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int hsw, lsw, fxw;
        rst_n = 1'b0; en = 1'b0; fb_cmp = 1'b0; oc_flag = 1'b0;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 hs_gate in reset", int'(hs_gate), 0);
        chk("R11 ls_gate in reset", int'(ls_gate), 0);
        chk("R11 period_stb in reset", int'(period_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk("R1 first strobe after enable", int'(period_stb), 1);

        // R9 ramp, R12 fixed ceiling, R5 low side with no pulse
        for (int k = 0; k < 2 * BL + 2; k++) begin
            run_period(0, 0, hsw, lsw, fxw);
            chk("R9 soft-start width", hsw, (k / BS < BL) ? k / BS : BL);
            if (k == 0) begin
                chk("R12 fixed limit first period", fxw, BL);
                chk("R5 low side with no pulse", lsw, ls_exp(0));
            end
            if (k == 2 * BL + 1)
                chk("R1 strobe each period", int'(period_stb), 1);
        end

        // Table of comparator and overcurrent stimuli
        for (int v = 0; v < NV; v++) begin
            run_period(VEC[v][0], VEC[v][1], hsw, lsw, fxw);
            chk("R2 R3 R4 R7 width with stimulus", hsw, VEC[v][2]);
            chk("R5 low-side width with stimulus", lsw, ls_exp(VEC[v][2]));
            run_period(0, 0, hsw, lsw, fxw);
            chk("R4 R8 width of following period", hsw, VEC[v][3]);
            chk("R5 low-side width of following period", lsw, ls_exp(VEC[v][3]));
        end

        // R10: drop enable mid-pulse, then re-enable restarts the ramp
        repeat (4) @(negedge clk);
        chk("R10 pulse present before disable", int'(hs_gate), 1);
        en = 1'b0;
        @(negedge clk);
        chk("R10 hs_gate after disable", int'(hs_gate), 0);
        chk("R10 ls_gate after disable", int'(ls_gate), 0);
        repeat (3) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk("R10 strobe after re-enable", int'(period_stb), 1);
        run_period(0, 0, hsw, lsw, fxw);
        chk("R10 ramp restarted", hsw, 0);
        chk("R12 fixed limit after re-enable", fxw, BL);

        // R11: reset applied mid-run
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 hs_gate after reset", int'(hs_gate) + int'(fx_hs), 0);
        chk("R11 ls_gate after reset", int'(ls_gate) + int'(fx_ls), 0);
        chk("R11 strobe after reset", int'(period_stb), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule